// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

The block gathers 32 interrupt sources into two processor-facing request lines, a normal request and a fast request. Every source is the OR of a hardware input and a software-set bit. A set-only enable register and its companion clear register gate each source. A per-source select bit sends an enabled source to the fast line or to the normal line.

Normal requests are vectored. Each source carries a 4-bit priority level and a 32-bit vector value. An arbiter picks the active source with the best level, and a 16-bit level mask can suppress whole levels. A read of the vector register hands the winning vector to software and opens a service frame. A write to the same register closes the frame. The open frames are held on a stack of levels, so a higher-level source can nest over one already in service. The fast line is a plain OR of its routed sources.

A protection bit limits register access to privileged transfers. The register port is a single-cycle bus: writes take effect at the clock edge of the request, and read data is combinational during the request cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The raw status (read at word 0x02) is the OR of the hardware inputs and the software bits. A change on `irq_src_i` shows in raw status only after two rising clock edges.
- R2: A 1 written to the enable-set word (0x04) sets that enable bit, and a 0 leaves it unchanged. A 1 written to the enable-clear word (0x05) clears that bit. Reading 0x04 returns the enables, which reset to 0.
- R3: The software word (0x06) sets bits on a 1 write, and the software-clear word (0x07) clears bits on a 1 write. The software bits reset to 0 and show in raw status one edge after the write.
- R4: A select bit (word 0x03) of 0 routes its source to the normal line and 1 routes it to the fast line. Select resets to all 0.
- R5: Normal status (word 0x00) is raw AND enable AND NOT select, and fast status (word 0x01) is raw AND enable AND select. `irq_o` is never high without some normal status bit set.
- R6: Each source has a level at word 0x80+i (bits 3:0) and a vector at word 0x40+i. Level 0 is highest and the reset level is 15. The winner is the active source with the lowest level, and among equal levels the lowest index wins.
- R7: The level mask (word 0x0A, bit n for level n) resets to 0xFFFF. A source whose level bit is 0 cannot win or raise `irq_o`.
- R8: A read of the vector word (0x09) while `irq_o` is high returns the winner's vector and opens its service frame. A read with `irq_o` low returns the last vector handed out, which resets to 0. Any write to 0x09 closes the newest frame.
- R9: When the protection bit (word 0x08, bit 0) is 1, a transfer with `priv_i` low has no effect and reads 0. The protection bit itself is readable and writable only with `priv_i` high.
- R10: While a frame is open, `irq_o` is raised only by a winner whose level is numerically below the newest open frame's level. Closing that frame restores the previous frame's level as the threshold.
- R11: `fiq_o` is the OR of the fast status bits and ignores levels, the level mask and open frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register transfer request |
| we_i | input | 1 | 1 = write, 0 = read |
| priv_i | input | 1 | Transfer is privileged |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during the request cycle |
| irq_src_i | input | 32 | Hardware interrupt inputs |
| irq_o | output | 1 | Normal vectored request |
| fiq_o | output | 1 | Fast request |

## Verification
The bench drives `irq_src_i` and samples raw status immediately, after one rising edge and after a second edge. The bit must appear only at the third sample. Software bits and register writes are due one edge after the write cycle. `irq_o` and `fiq_o` are combinational from registered state, so they are checked at the falling edge that ends a write or an acknowledging read. Arbitration results come from vector reads compared against a winner the bench works out itself from the programmed levels and mask.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_IRQ_STAT = 8'h00;
  localparam logic [ADDR_W-1:0] A_FIQ_STAT = 8'h01;
  localparam logic [ADDR_W-1:0] A_RAW      = 8'h02;
  localparam logic [ADDR_W-1:0] A_SEL      = 8'h03;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 8'h04;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 8'h05;
  localparam logic [ADDR_W-1:0] A_SW_SET   = 8'h06;
  localparam logic [ADDR_W-1:0] A_SW_CLR   = 8'h07;
  localparam logic [ADDR_W-1:0] A_PROT     = 8'h08;
  localparam logic [ADDR_W-1:0] A_VEC      = 8'h09;
  localparam logic [ADDR_W-1:0] A_LVL_MASK = 8'h0A;
  // 0x40+i : vector of source i, 0x80+i : level of source i
  localparam logic [1:0] VEC_REGION = 2'b01;
  localparam logic [2:0] LVL_REGION = 3'b100;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0][PW-1:0] lvl_i,
  output logic                 found_o,
  output logic [IW-1:0]        idx_o,
  output logic [PW-1:0]        lvl_o
);
  // strict compare keeps the lowest index on a tie
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '1;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!found_o || lvl_i[i] < lvl_o)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int unsigned PW = 4,
  localparam int unsigned DEPTH = 2 ** PW,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [PW-1:0] push_lvl_i,
  input  logic          pop_i,
  output logic          empty_o,
  output logic [PW-1:0] top_o,
  output logic [CW-1:0] depth_o
);
  logic [DEPTH-1:0][PW-1:0] lvl_q;
  logic [CW-1:0]            cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '1;
      cnt_q <= '0;
    end else if (push_i && cnt_q != CW'(DEPTH)) begin
      lvl_q[IW'(cnt_q)] <= push_lvl_i;
      cnt_q             <= cnt_q + 1'b1;
    end else if (pop_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign empty_o = (cnt_q == '0);
  assign top_o   = empty_o ? '1 : lvl_q[IW'(cnt_q - 1'b1)];
  assign depth_o = cnt_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned NLVL  = 2 ** PRIO_W,
  localparam int unsigned SRC_W = $clog2(NUM_SRC),
  localparam int unsigned CW    = $clog2(NLVL + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               priv_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] irq_src_i,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [NUM_SRC-1:0]             hw_sync, en_q, sel_q, soft_q;
  logic [NUM_SRC-1:0]             raw, irq_stat, fiq_stat, cand;
  logic [NUM_SRC-1:0][DATA_W-1:0] vaddr_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NLVL-1:0]                mask_q;
  logic [DATA_W-1:0]              vec_q;
  logic                           prot_q;
  logic                           found, stk_empty;
  logic [SRC_W-1:0]               win_idx, sidx;
  logic [PRIO_W-1:0]              win_prio, stk_top;
  logic [CW-1:0]                  depth;
  logic                           acc_ok, rd_en, wr_en, vec_hit, lvl_hit, ack, done;

  irq_sync #(.W(NUM_SRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_src_i), .q_o(hw_sync)
  );

  assign raw      = hw_sync | soft_q;
  assign irq_stat = raw & en_q & ~sel_q;
  assign fiq_stat = raw & en_q & sel_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cand
    assign cand[g] = irq_stat[g] & mask_q[prio_q[g]];
  end

  irq_prio_arb #(.N(NUM_SRC), .PW(PRIO_W)) u_arb (
    .req_i(cand), .lvl_i(prio_q), .found_o(found), .idx_o(win_idx), .lvl_o(win_prio)
  );

  irq_nest_stack #(.PW(PRIO_W)) u_stk (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(ack), .push_lvl_i(win_prio),
    .pop_i(done), .empty_o(stk_empty), .top_o(stk_top), .depth_o(depth)
  );

  assign irq_o = found & (stk_empty | (win_prio < stk_top));
  assign fiq_o = |fiq_stat;

  assign acc_ok  = priv_i | ~prot_q;
  assign rd_en   = req_i & ~we_i & acc_ok;
  assign wr_en   = req_i & we_i & acc_ok;
  assign sidx    = addr_i[SRC_W-1:0];
  assign vec_hit = (addr_i[7:6] == VEC_REGION);
  assign lvl_hit = (addr_i[7:5] == LVL_REGION);
  assign ack     = rd_en & (addr_i == A_VEC) & irq_o;
  assign done    = wr_en & (addr_i == A_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      sel_q   <= '0;
      soft_q  <= '0;
      prot_q  <= 1'b0;
      mask_q  <= '1;
      vec_q   <= '0;
      vaddr_q <= '0;
      prio_q  <= '1;
    end else begin
      if (ack) vec_q <= vaddr_q[win_idx];
      if (wr_en) begin
        if (vec_hit) vaddr_q[sidx] <= wdata_i;
        if (lvl_hit) prio_q[sidx] <= wdata_i[PRIO_W-1:0];
        unique case (addr_i)
          A_SEL:      sel_q  <= wdata_i[NUM_SRC-1:0];
          A_EN_SET:   en_q   <= en_q | wdata_i[NUM_SRC-1:0];
          A_EN_CLR:   en_q   <= en_q & ~wdata_i[NUM_SRC-1:0];
          A_SW_SET:   soft_q <= soft_q | wdata_i[NUM_SRC-1:0];
          A_SW_CLR:   soft_q <= soft_q & ~wdata_i[NUM_SRC-1:0];
          A_PROT:     if (priv_i) prot_q <= wdata_i[0];
          A_LVL_MASK: mask_q <= wdata_i[NLVL-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (vec_hit) rdata_o = vaddr_q[sidx];
      else if (lvl_hit) rdata_o = DATA_W'(prio_q[sidx]);
      else begin
        unique case (addr_i)
          A_IRQ_STAT: rdata_o = DATA_W'(irq_stat);
          A_FIQ_STAT: rdata_o = DATA_W'(fiq_stat);
          A_RAW:      rdata_o = DATA_W'(raw);
          A_SEL:      rdata_o = DATA_W'(sel_q);
          A_EN_SET:   rdata_o = DATA_W'(en_q);
          A_SW_SET:   rdata_o = DATA_W'(soft_q);
          A_PROT:     rdata_o = DATA_W'(prot_q & priv_i);
          A_VEC:      rdata_o = irq_o ? vaddr_q[win_idx] : vec_q;
          A_LVL_MASK: rdata_o = DATA_W'(mask_q);
          default:    rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk
  import irq_vec_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 4,
  parameter int unsigned CW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              priv_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      wdata_i,
  input logic [N-1:0]      hw_sync,
  input logic [N-1:0]      soft_q,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      sel_q,
  input logic              prot_q,
  input logic [2**PW-1:0]  mask_q,
  input logic [PW-1:0]     win_prio,
  input logic [CW-1:0]     depth,
  input logic              irq_o,
  input logic              fiq_o
);
  AST_EN_SET_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (priv_i || !prot_q) && addr_i == A_EN_SET) |=>
      ((en_q & $past(en_q)) == $past(en_q)) && ((en_q & $past(wdata_i)) == $past(wdata_i))); // R2

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |((hw_sync | soft_q) & en_q & ~sel_q)); // R5

  AST_MASKED_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mask_q[win_prio]); // R7

  AST_PROT_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && prot_q && !priv_i) |=>
      ($stable(en_q) && $stable(soft_q) && $stable(sel_q) && $stable(prot_q))); // R9

  AST_PUSH_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth > $past(depth)) |-> $past(irq_o && req_i && !we_i && addr_i == A_VEC)); // R10

  AST_FIQ_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> |((hw_sync | soft_q) & en_q & sel_q)); // R11
endmodule

bind irq_vector_ctrl irq_vec_chk #(.N(NUM_SRC), .PW(PRIO_W), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .priv_i(priv_i),
  .addr_i(addr_i), .wdata_i(wdata_i[NUM_SRC-1:0]), .hw_sync(hw_sync), .soft_q(soft_q),
  .en_q(en_q), .sel_q(sel_q), .prot_q(prot_q), .mask_q(mask_q), .win_prio(win_prio),
  .depth(depth), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, priv = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic [31:0] irq_src = '0;
  logic        irq, fiq;
  int          n_chk = 0, n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .priv_i(priv),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_src_i(irq_src), .irq_o(irq), .fiq_o(fiq)
  );

  function automatic logic [31:0] vexp(int i);
    return 32'h1000 + 32'(4 * i);
  endfunction

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic p = 1'b1);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; priv = p;
    @(negedge clk);
    req = 1'b0; we = 1'b0; priv = 1'b1;
  endtask

  task automatic rd(logic [7:0] a, logic p = 1'b1);
    req = 1'b1; we = 1'b0; addr = a; priv = p;
    #1 rv = rdata;
    @(negedge clk);
    req = 1'b0; priv = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int best, bi, b2, bi2, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(8'h04); chk("R2 enable reset", rv, 0);
    rd(8'h06); chk("R3 soft reset", rv, 0);
    rd(8'h03); chk("R4 select reset", rv, 0);
    rd(8'h85); chk("R6 level reset", rv, 15);
    rd(8'h0A); chk("R7 mask reset", rv, 32'hFFFF);
    rd(8'h09); chk("R8 vector reset", rv, 0);
    chk("R5 irq reset", 32'(irq), 0);
    chk("R11 fiq reset", 32'(fiq), 0);

    // R1: two-edge input delay
    irq_src = 32'h8;
    rd(8'h02); chk("R1 raw before edge", rv, 0);
    rd(8'h02); chk("R1 raw after one edge", rv, 0);
    rd(8'h02); chk("R1 raw after two edges", rv, 32'h8);
    irq_src = '0;
    repeat (2) @(negedge clk);

    // R6/R8: vector per source, ack and completion
    for (int i = 0; i < 32; i++) wr(8'h40 + 8'(i), vexp(i));
    wr(8'h04, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      irq_src = 32'h1 << i;
      repeat (2) @(negedge clk);
      chk("R5 irq for source", 32'(irq), 1);
      rd(8'h09); chk("R8 vector of source", rv, vexp(i));
      wr(8'h09, 0);
      irq_src = '0;
      repeat (2) @(negedge clk);
      chk("R5 irq idle", 32'(irq), 0);
    end
    rd(8'h09); chk("R8 last vector kept", rv, vexp(31));

    // R4/R11: fast routing
    wr(8'h03, 32'hFFFF_FFFF);
    irq_src = 32'h1000;
    repeat (2) @(negedge clk);
    chk("R4 fiq routed", 32'(fiq), 1);
    chk("R4 irq not routed", 32'(irq), 0);
    rd(8'h01); chk("R5 fast status", rv, 32'h1000);
    rd(8'h00); chk("R5 normal status", rv, 0);
    wr(8'h0A, 0);
    chk("R11 fiq ignores mask", 32'(fiq), 1);
    wr(8'h0A, 32'hFFFF);
    wr(8'h03, 0);
    chk("R4 back to irq", 32'(irq), 1);
    chk("R4 fiq off", 32'(fiq), 0);
    irq_src = '0;
    repeat (2) @(negedge clk);

    // R2/R3: set and clear words
    wr(8'h06, 32'h80);
    rd(8'h02); chk("R3 soft in raw", rv, 32'h80);
    chk("R3 soft raises irq", 32'(irq), 1);
    wr(8'h05, 32'h80);
    rd(8'h00); chk("R2 cleared status", rv, 0);
    chk("R2 cleared irq", 32'(irq), 0);
    wr(8'h04, 0);
    rd(8'h04); chk("R2 zero write no effect", rv, 32'hFFFF_FF7F);
    wr(8'h04, 32'h80);
    wr(8'h07, 32'h80);
    rd(8'h06); chk("R3 soft cleared", rv, 0);
    rd(8'h02); chk("R3 raw cleared", rv, 0);

    // R6/R7: level sweep with and without masking the winning level
    wr(8'h06, 32'hFFFF_FFFF);
    for (int k = 0; k < 16; k++) begin
      best = 16; bi = 0; b2 = 16; bi2 = 0;
      for (int i = 0; i < 32; i++) begin
        p = (i * 7 + k * 3) % 16;
        wr(8'h80 + 8'(i), 32'(p));
        if (p < best) begin best = p; bi = i; end
      end
      for (int i = 0; i < 32; i++) begin
        p = (i * 7 + k * 3) % 16;
        if (p != best && p < b2) begin b2 = p; bi2 = i; end
      end
      rd(8'h09); chk("R6 winner vector", rv, vexp(bi));
      wr(8'h09, 0);
      wr(8'h0A, 32'hFFFF & ~(32'h1 << best));
      rd(8'h09); chk("R7 masked level skipped", rv, vexp(bi2));
      wr(8'h09, 0);
      wr(8'h0A, 32'hFFFF);
    end
    wr(8'h07, 32'hFFFF_FFFF);

    // R6 tie at default level, R10 nesting
    for (int i = 0; i < 32; i++) wr(8'h80 + 8'(i), 15);
    wr(8'h06, 32'h0010_0010);
    rd(8'h09); chk("R6 tie lowest index", rv, vexp(4));
    wr(8'h09, 0);
    wr(8'h07, 32'hFFFF_FFFF);
    wr(8'h82, 5); wr(8'h89, 5); wr(8'h8A, 3);
    wr(8'h06, 32'h4);
    chk("R10 first irq", 32'(irq), 1);
    rd(8'h09); chk("R10 ack source 2", rv, vexp(2));
    chk("R10 masked by own level", 32'(irq), 0);
    wr(8'h06, 32'h200);
    chk("R10 equal level blocked", 32'(irq), 0);
    wr(8'h06, 32'h400);
    chk("R10 higher level nests", 32'(irq), 1);
    rd(8'h09); chk("R10 ack source 10", rv, vexp(10));
    chk("R10 blocked at level 3", 32'(irq), 0);
    wr(8'h09, 0);
    chk("R10 pop restores level 5", 32'(irq), 1);
    wr(8'h07, 32'h400);
    chk("R10 equal level still blocked", 32'(irq), 0);
    wr(8'h09, 0);
    chk("R10 empty stack", 32'(irq), 1);
    rd(8'h09); chk("R10 tie after pop", rv, vexp(2));
    wr(8'h09, 0);
    wr(8'h07, 32'hFFFF_FFFF);

    // R9: protection
    wr(8'h08, 1);
    wr(8'h05, 32'hFFFF_FFFF, 1'b0);
    rd(8'h04); chk("R9 user write refused", rv, 32'hFFFF_FFFF);
    rd(8'h04, 1'b0); chk("R9 user read zero", rv, 0);
    wr(8'h08, 0, 1'b0);
    rd(8'h08); chk("R9 user cannot unlock", rv, 1);
    wr(8'h08, 0);
    wr(8'h08, 1, 1'b0);
    rd(8'h08); chk("R9 user cannot lock", rv, 0);
    wr(8'h05, 32'h1, 1'b0);
    rd(8'h04); chk("R9 user write when open", rv, 32'hFFFF_FFFE);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule